// File: doc/BRIEF.md
# Row-Holding DRAM Access Sequencer with Refresh

This block connects a simple byte-wide processor request port to a 2M x 8 asynchronous-style DRAM whose address pins are shared between row and column. A 21-bit byte address is split into a 12-bit row (bits 20..9) and a 9-bit column (bits 8..0). The controller drives the row onto the shared pins and asserts the row strobe. After the row-to-column delay it drives the column and asserts the column strobe. It then leaves the row active, so a later access to the same row needs only a new column cycle.

An internal timer raises a refresh request once per per-row interval. The interval is the refresh period divided by the 4096 rows, with both values in clock cycles. A pending refresh wins over a new processor request, but it never interrupts an access that has already started. It closes any open row, precharges, and runs a row-strobe-only cycle on the row named by an internal counter. That counter steps through every row in turn. The processor holds `req` until it sees the one-cycle `done` pulse.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ras_n`, `cas_n`, `we_n` and `cs_n` are high and `done` is low.
- R2: When `ras_n` falls for an access, `mem_addr` carries address bits 20..9. While `cas_n` is low, `mem_addr` carries bits 8..0 zero-extended. `cas_n` is never low while `ras_n` is high.
- R3: A write stores `wdata` into the addressed byte, with `we_n` low during the column cycle. A read returns the byte stored at its address on `rdata`, valid while `done` is high.
- R4: An access to the row that the previous access left open, with no refresh since, causes no new falling edge of `ras_n`. An access to any other row causes exactly one.
- R5: Between any rise of `ras_n` and its next fall, `ras_n` stays high for at least `T_RP` cycles.
- R6: A refresh is a period with `ras_n` low and no `cas_n` pulse, lasting exactly `T_REF` cycles. Successive refreshes address rows 0, 1, 2, ... in order, and the row number wraps modulo 4096.
- R7: The end of one refresh and the end of the next are at most INTERVAL + 2*T_RP + T_RCD + T_CAS + T_REF + 4 cycles apart, where INTERVAL = REF_PERIOD_CYC / 4096. The same bound applies from reset to the first refresh.
- R8: `done` is high for exactly one cycle per accepted access.
- R9: `cas_n` falls no sooner than `T_RCD` cycles after the most recent fall of `ras_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until `done` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 21 | Byte address: row in bits 20..9, column in bits 8..0 |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 12 | Shared row/column address pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable to DRAM, active low |
| cs_n | output | 1 | Chip select, active low |
| mem_dout | output | 8 | Data driven to DRAM |
| mem_oe | output | 1 | Qualifies `mem_dout` during a write column cycle |
| mem_din | input | 8 | Data returned by DRAM |

## Verification
If the sequencer loses track of the open row, the error shows at the next column cycle. A needless row activation, or a missing one that reaches the wrong row, is visible in the `ras_n` edges and in the row captured at the row strobe. If the refresh row counter or the refresh timer is wrong, the error shows at the end of the next refresh cycle. It appears as a skipped row number, a wrong strobe width or an overlong gap, and is caught within one refresh interval plus the longest access. If the state machine takes a wrong turn in its timing, the error shows on the first strobe edge that breaks the precharge or row-to-column spacing.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_COL, ST_DONE, ST_OPEN, ST_REF, ST_RPRE
  } dstate_t;

  typedef enum logic [1:0] {
    AMUX_ROW, AMUX_COL, AMUX_REF
  } amux_t;
endpackage

// File: rtl/dram_ref_sched.sv
module dram_ref_sched #(
  parameter int ROW_W    = 12,
  parameter int INTERVAL = 1953
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  output logic             pend,
  output logic [ROW_W-1:0] row
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             pend_d, tick;
  logic [ROW_W-1:0] row_d;

  always_comb begin
    tick   = (cnt_q == CW'(INTERVAL - 1));
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    pend_d = tick | (pend & ~ack);
    row_d  = ack ? row + 1'b1 : row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pend  <= 1'b0;
      row   <= '0;
    end else begin
      cnt_q <= cnt_d;
      pend  <= pend_d;
      if (ack) row <= row_d;
    end
  end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_pkg::*;
#(
  parameter int T_RP  = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_REF = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req,
  input  logic  row_hit,
  input  logic  ref_pend,
  input  logic  lat_we,
  output logic  ld_req,
  output logic  cap_rd,
  output logic  ref_ack,
  output logic  done,
  output logic  ras_n,
  output logic  cas_n,
  output logic  we_n,
  output logic  wr_drive,
  output amux_t amux
);
  localparam int M1   = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int M2   = (T_CAS > T_REF) ? T_CAS : T_REF;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXT + 1);

  dstate_t       st_q, st_d;
  logic [TW-1:0] tm_q, tm_d, tval;
  logic          to_ref_q, to_ref_d;
  logic          tm_zero;

  assign tm_zero = (tm_q == '0);

  always_comb begin
    st_d     = st_q;
    to_ref_d = to_ref_q;
    tval     = '0;
    ld_req   = 1'b0;
    cap_rd   = 1'b0;
    ref_ack  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_pend) begin
          st_d = ST_REF;
          tval = TW'(T_REF - 1);
        end else if (req) begin
          ld_req = 1'b1;
          st_d   = ST_ACT;
          tval   = TW'(T_RCD - 1);
        end
      end
      ST_OPEN: begin
        if (ref_pend) begin
          st_d     = ST_PRE;
          to_ref_d = 1'b1;
          tval     = TW'(T_RP - 1);
        end else if (req) begin
          ld_req = 1'b1;
          if (row_hit) begin
            st_d = ST_COL;
            tval = TW'(T_CAS - 1);
          end else begin
            st_d     = ST_PRE;
            to_ref_d = 1'b0;
            tval     = TW'(T_RP - 1);
          end
        end
      end
      ST_PRE: begin
        if (tm_zero) begin
          if (to_ref_q) begin
            st_d = ST_REF;
            tval = TW'(T_REF - 1);
          end else begin
            st_d = ST_ACT;
            tval = TW'(T_RCD - 1);
          end
        end
      end
      ST_ACT: begin
        if (tm_zero) begin
          st_d = ST_COL;
          tval = TW'(T_CAS - 1);
        end
      end
      ST_COL: begin
        if (tm_zero) begin
          cap_rd = 1'b1;
          st_d   = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_OPEN;
      ST_REF: begin
        if (tm_zero) begin
          ref_ack = 1'b1;
          st_d    = ST_RPRE;
          tval    = TW'(T_RP - 1);
        end
      end
      ST_RPRE: if (tm_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (st_d != st_q) tm_d = tval;
    else              tm_d = tm_zero ? '0 : tm_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      tm_q     <= '0;
      to_ref_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      tm_q     <= tm_d;
      to_ref_q <= to_ref_d;
    end
  end

  always_comb begin
    ras_n    = !(st_q inside {ST_ACT, ST_COL, ST_DONE, ST_OPEN, ST_REF});
    cas_n    = (st_q != ST_COL);
    wr_drive = (st_q == ST_COL) && lat_we;
    we_n     = !wr_drive;
    done     = (st_q == ST_DONE);
    case (st_q)
      ST_REF:  amux = AMUX_REF;
      ST_COL:  amux = AMUX_COL;
      default: amux = AMUX_ROW;
    endcase
  end
endmodule

// File: rtl/dram_pin_mux.sv
module dram_pin_mux
  import dram_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  parameter int PIN_W = 12
) (
  input  amux_t            sel,
  input  logic [ROW_W-1:0] acc_row,
  input  logic [COL_W-1:0] acc_col,
  input  logic [ROW_W-1:0] ref_row,
  output logic [PIN_W-1:0] pins
);
  always_comb begin
    case (sel)
      AMUX_COL: pins = PIN_W'(acc_col);
      AMUX_REF: pins = PIN_W'(ref_row);
      default:  pins = PIN_W'(acc_row);
    endcase
  end
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_pkg::*;
#(
  parameter int ROW_W          = 12,
  parameter int COL_W          = 9,
  parameter int DATA_W         = 8,
  parameter int T_RP           = 2,
  parameter int T_RCD          = 2,
  parameter int T_CAS          = 2,
  parameter int T_REF          = 4,
  parameter int REF_PERIOD_CYC = 8000000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req,
  input  logic                         we,
  input  logic [ROW_W+COL_W-1:0]       addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic                         done,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] mem_addr,
  output logic                         ras_n,
  output logic                         cas_n,
  output logic                         we_n,
  output logic                         cs_n,
  output logic [DATA_W-1:0]            mem_dout,
  output logic                         mem_oe,
  input  logic [DATA_W-1:0]            mem_din
);
  localparam int ADDR_W   = ROW_W + COL_W;
  localparam int PIN_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int INTERVAL = REF_PERIOD_CYC / ROWS;

  logic [ROW_W-1:0]  lat_row, ref_row;
  logic [COL_W-1:0]  lat_col;
  logic              lat_we;
  logic [DATA_W-1:0] lat_wdata;
  logic              ld_req, cap_rd, ref_ack, ref_pend, row_hit;
  amux_t             amux;

  assign row_hit = (addr[ADDR_W-1:COL_W] == lat_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_row   <= '0;
      lat_col   <= '0;
      lat_we    <= 1'b0;
      lat_wdata <= '0;
    end else if (ld_req) begin
      lat_row   <= addr[ADDR_W-1:COL_W];
      lat_col   <= addr[COL_W-1:0];
      lat_we    <= we;
      lat_wdata <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_rd) rdata <= mem_din;
  end

  dram_ref_sched #(.ROW_W(ROW_W), .INTERVAL(INTERVAL)) u_sched (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend), .row(ref_row)
  );

  dram_seq_fsm #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_REF(T_REF)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .row_hit(row_hit), .ref_pend(ref_pend),
    .lat_we(lat_we), .ld_req(ld_req), .cap_rd(cap_rd), .ref_ack(ref_ack),
    .done(done), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .wr_drive(mem_oe),
    .amux(amux)
  );

  dram_pin_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_mux (
    .sel(amux), .acc_row(lat_row), .acc_col(lat_col), .ref_row(ref_row),
    .pins(mem_addr)
  );

  assign cs_n     = ras_n & cas_n;
  assign mem_dout = lat_wdata;
endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk #(
  parameter int ROW_W    = 12,
  parameter int PIN_W    = 12,
  parameter int T_RP     = 2,
  parameter int T_RCD    = 2,
  parameter int T_CAS    = 2,
  parameter int T_REF    = 4,
  parameter int INTERVAL = 1953
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             cs_n,
  input logic             done,
  input logic [PIN_W-1:0] mem_addr
);
  localparam int LIMIT = INTERVAL + 2*T_RP + T_RCD + T_CAS + T_REF + 4;

  logic [7:0]       lo_cnt, hi_cnt;
  logic             prev_ras, cas_seen;
  logic [ROW_W-1:0] fall_row, last_ref;
  logic [31:0]      gap;
  logic             ref_end;

  assign ref_end = ras_n && !prev_ras && !cas_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt   <= '0;
      hi_cnt   <= 8'hff;
      prev_ras <= 1'b1;
      cas_seen <= 1'b0;
      fall_row <= '0;
      last_ref <= '1;
      gap      <= '0;
    end else begin
      prev_ras <= ras_n;
      lo_cnt   <= ras_n ? '0 : ((lo_cnt == 8'hff) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt   <= !ras_n ? '0 : ((hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 1'b1);
      if (!ras_n && prev_ras) begin
        cas_seen <= !cas_n;
        fall_row <= mem_addr[ROW_W-1:0];
      end else if (!cas_n) begin
        cas_seen <= 1'b1;
      end
      if (ref_end) begin
        last_ref <= fall_row;
        gap      <= '0;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk) !rst_n |=> (ras_n && cas_n && we_n && cs_n && !done)); // R1
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> !ras_n); // R2
  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> hi_cnt >= 8'(T_RP)); // R5
  AST_REF_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) ref_end |-> lo_cnt == 8'(T_REF)); // R6
  AST_REF_ORDER: assert property (@(posedge clk) disable iff (!rst_n) ref_end |-> fall_row == last_ref + 1'b1); // R6
  AST_REF_CADENCE: assert property (@(posedge clk) disable iff (!rst_n) gap <= 32'(LIMIT)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_RAS_TO_CAS: assert property (@(posedge clk) disable iff (!rst_n) $fell(cas_n) |-> lo_cnt >= 8'(T_RCD)); // R9
endmodule

bind dram_page_ctrl dram_page_ctrl_chk #(
  .ROW_W(ROW_W), .PIN_W(PIN_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
  .T_REF(T_REF), .INTERVAL(INTERVAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .cs_n(cs_n), .done(done), .mem_addr(mem_addr)
);

// File: tb/dram_page_ctrl_tb.sv
module dram_page_ctrl_tb;
  localparam int T_RP = 2, T_RCD = 3, T_CAS = 2, T_REF = 4;
  localparam int INTERVAL = 100;
  localparam int LIMIT = INTERVAL + 2*T_RP + T_RCD + T_CAS + T_REF + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [20:0] addr = '0;
  logic [7:0] wdata = '0, rdata, mem_dout, mem_din = '0;
  logic [11:0] mem_addr;
  logic done, ras_n, cas_n, we_n, cs_n, mem_oe;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dram_page_ctrl #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_REF(T_REF),
                   .REF_PERIOD_CYC(4096*INTERVAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .mem_addr(mem_addr), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cs_n(cs_n), .mem_dout(mem_dout),
    .mem_oe(mem_oe), .mem_din(mem_din)
  );

  typedef struct {
    bit          rd;
    logic [7:0]  d;
    logic [11:0] row;
    logic [8:0]  col;
  } item_t;

  item_t q[$];
  item_t cur;
  logic [7:0] shadow[int];
  logic [7:0] dram[int];

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", r, act, exp, $time);
    end
  endtask

  // Driver: pushes expected items, runs the request handshake
  task automatic access(input bit w, input logic [20:0] a, input logic [7:0] d);
    item_t it;
    it.rd  = !w;
    it.row = a[20:9];
    it.col = a[8:0];
    if (w) shadow[int'(a)] = d;
    it.d = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    q.push_back(it);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    do @(negedge clk); while (!done);
    req = 1'b0;
  endtask

  // DRAM model and monitor, sampled on the falling clock edge
  logic        p_ras = 1'b1, p_cas = 1'b1, p_done = 1'b0;
  logic [11:0] cur_row = '0;
  int          lo = 0, hi = 1000, ref_cnt = 0, ref_at_cas = -1, gap = 0;
  bit          act_since_cas = 0, cas_in_win = 0, have_prev = 0;
  logic [11:0] prev_row = '0, exp_ref = '0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      gap++;
      if (!ras_n && p_ras) begin
        chk(hi >= T_RP, "R5 precharge", hi, T_RP);
        cur_row = mem_addr;
        act_since_cas = 1; cas_in_win = 0;
      end
      if (ras_n && !p_ras && !cas_in_win) begin
        chk(lo == T_REF, "R6 refresh width", lo, T_REF);
        chk(cur_row == exp_ref, "R6 refresh row", cur_row, exp_ref);
        chk(gap <= LIMIT, "R7 refresh gap", gap, LIMIT);
        exp_ref = exp_ref + 1'b1;
        ref_cnt++; gap = 0;
      end
      if (!cas_n && p_cas) begin
        cas_in_win = 1;
        chk(!ras_n && lo >= T_RCD, "R9 ras-to-cas", lo, T_RCD);
        if (q.size() == 0) chk(0, "R2 unexpected column cycle", 1, 0);
        else begin
          cur = q.pop_front();
          chk(cur_row == cur.row, "R2 row bits", cur_row, cur.row);
          chk(mem_addr == {3'b000, cur.col}, "R2 column bits", mem_addr, cur.col);
          chk(act_since_cas == !(have_prev && prev_row == cur.row && ref_at_cas == ref_cnt),
              "R4 row activation", act_since_cas, !(have_prev && prev_row == cur.row && ref_at_cas == ref_cnt));
          chk(we_n == cur.rd, "R3 write enable", we_n, cur.rd);
          if (!we_n) dram[int'({cur_row, mem_addr[8:0]})] = mem_dout;
          mem_din = dram.exists(int'({cur_row, mem_addr[8:0]})) ? dram[int'({cur_row, mem_addr[8:0]})] : 8'h00;
          have_prev = 1; prev_row = cur.row; ref_at_cas = ref_cnt;
          act_since_cas = 0;
        end
      end
      if (done) begin
        chk(!p_done, "R8 done width", 2, 1);
        if (cur.rd) chk(rdata == cur.d, "R3 read data", rdata, cur.d);
      end
      lo = ras_n ? 0 : lo + 1;
      hi = ras_n ? hi + 1 : 0;
      p_ras = ras_n; p_cas = cas_n; p_done = done;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && cs_n && !done, "R1 reset pins", {ras_n, cas_n, we_n, cs_n, done}, 5'b11110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && cs_n && !done, "R1 after release", {ras_n, cas_n, cs_n, done}, 4'b1110);
    access(1, 21'h000000, 8'h11);
    access(1, 21'h000005, 8'h22);  // R4 same row
    access(1, 21'h0001FF, 8'h33);  // R4 same row, top column
    access(1, 21'h1FFFFF, 8'h44);  // R2 top row and column
    access(1, 21'h00A203, 8'h55);
    access(0, 21'h000005, 8'h00);  // R3 read back
    access(0, 21'h000000, 8'h00);
    access(0, 21'h0001FF, 8'h00);
    access(0, 21'h1FFFFF, 8'h00);
    access(0, 21'h00A203, 8'h00);
    access(1, 21'h00A203, 8'hA5);  // overwrite, same row
    access(0, 21'h00A203, 8'h00);
    for (int i = 0; i < 40; i++) begin
      access(1, 21'((i % 3) << 9 | i), 8'(i * 7 + 1));
      access(0, 21'((i % 3) << 9 | i), 8'h00);
    end
    repeat (5 * INTERVAL) @(negedge clk);
    chk(ref_cnt >= 8, "R7 refresh count", ref_cnt, 8);
    for (int i = 0; i < 20; i++) access(0, 21'(i % 2 ? 21'h1FFFFF : 21'h000005), 8'h00);
    chk(q.size() == 0, "R3 all accesses completed", q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule